// File: doc/BRIEF.md
# Capture Channel Source Select and Prescaler

This block is the front end of one capture channel in a two-channel timer. A two-bit source field picks what feeds the channel: nothing (the channel is used as an output, so it never captures), the channel's own filtered input, the sibling channel's filtered input, or an internal trigger. The internal trigger only counts while a separate trigger-source-valid input is high. Active edges of the chosen signal are found by comparing it with its level one cycle earlier. The polarity input selects either rising or falling edges.

Active edges pass through a divider that passes every edge, every 2nd, every 4th or every 8th. Each edge that gets through is a capture event. On a capture event the free-running 16-bit counter value is latched into the capture register and a sticky capture flag is set. A capture that arrives while the flag is still set also raises an overcapture flag. A clear strobe drops both flags.

The source field can only be written while the channel enable is low. While the enable is low the divider is held cleared and no capture happens. The input filters and the counter are outside this block.

Top module: `capture_front`

## Requirements
- R1: After reset, sel_o is 00, cap_o is 0, and flag_o and ovr_o are 0.
- R2: With source code 00 (output use) no capture ever happens: cap_o and flag_o do not change because of any edge input.
- R3: Source code 01 takes edges from own_i. Source code 10 takes edges from sib_i. Edges on the input that is not selected cause no capture.
- R4: Source code 11 takes edges from trig_i, but only in cycles where trig_ok_i is 1. While trig_ok_i is 0, trigger edges cause no capture.
- R5: A write of sel_i with sel_wr_i high takes effect on sel_o in the next cycle when en_i is 0, and is ignored when en_i is 1.
- R6: Divider code psc_i 00 captures on every active edge. Codes 01, 10 and 11 capture on every 2nd, 4th and 8th active edge counted since the channel was last enabled.
- R7: In any cycle where en_i is 0 the edge divider is cleared and no capture happens.
- R8: With pol_i = 0 the active edge is a 0 to 1 change of the selected source against its level in the previous cycle. With pol_i = 1 it is a 1 to 0 change.
- R9: A capture event in a cycle latches that cycle's cnt_i into cap_o and sets flag_o from the next cycle on. clr_i clears flag_o and ovr_o. If a capture and clr_i fall in the same cycle, flag_o ends at 1 and ovr_o at 0.
- R10: A capture event while flag_o is 1 and clr_i is 0 sets ovr_o. ovr_o is never 1 while flag_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable |
| sel_wr_i | input | 1 | Write strobe for the source field |
| sel_i | input | 2 | Source code: 00 off, 01 own, 10 sibling, 11 trigger |
| psc_i | input | 2 | Edge divider code: 00 /1, 01 /2, 10 /4, 11 /8 |
| pol_i | input | 1 | Active edge: 0 rising, 1 falling |
| own_i | input | 1 | Own filtered input |
| sib_i | input | 1 | Sibling channel filtered input |
| trig_i | input | 1 | Internal trigger |
| trig_ok_i | input | 1 | Trigger source is valid |
| cnt_i | input | 16 | Counter value to capture |
| clr_i | input | 1 | Clears capture and overcapture flags |
| sel_o | output | 2 | Current source field |
| cap_o | output | 16 | Capture register |
| flag_o | output | 1 | Capture flag |
| ovr_o | output | 1 | Overcapture flag |

## Verification
The assertions rely on all inputs being synchronous to clk_i and stable around each rising edge. The bench drives every input on the falling edge. The bench also keeps psc_i constant while the channel is enabled: a divider code change mid-run would move the capture point, and no requirement defines where it lands. So the random stimulus changes psc_i, pol_i and the source only in disabled windows. During enabled windows it toggles the edge inputs, trig_ok_i, clr_i and write attempts freely.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    SRC_OFF = 2'b00,
    SRC_OWN = 2'b01,
    SRC_SIB = 2'b10,
    SRC_TRG = 2'b11
  } src_sel_e;

  // low bits set for a divide-by-2**code terminal value
  function automatic logic [7:0] div_mask(input logic [2:0] code);
    logic [7:0] m;
    for (int i = 0; i < 8; i++) m[i] = (i < int'(code));
    return m;
  endfunction
endpackage

// File: rtl/cap_sel_reg.sv
module cap_sel_reg
  import cap_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       wr_i,
  input  logic [1:0] sel_i,
  output src_sel_e   sel_o
);
  src_sel_e sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            sel_q <= SRC_OFF;
    else if (wr_i && !en_i) sel_q <= src_sel_e'(sel_i);
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/cap_edge_src.sv
module cap_edge_src
  import cap_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  src_sel_e sel_i,
  input  logic     pol_i,
  input  logic     own_i,
  input  logic     sib_i,
  input  logic     trig_i,
  input  logic     trig_ok_i,
  output logic     act_o
);
  logic lvl, lvl_q, src_ok, rise, fall;

  always_comb begin
    unique case (sel_i)
      SRC_OWN: begin lvl = own_i;  src_ok = 1'b1;      end
      SRC_SIB: begin lvl = sib_i;  src_ok = 1'b1;      end
      SRC_TRG: begin lvl = trig_i; src_ok = trig_ok_i; end
      default: begin lvl = 1'b0;   src_ok = 1'b0;      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl;
  end

  assign rise  = lvl & ~lvl_q;
  assign fall  = ~lvl & lvl_q;
  assign act_o = en_i & src_ok & (pol_i ? fall : rise);
endmodule

// File: rtl/cap_presc.sv
module cap_presc
  import cap_pkg::*;
#(
  parameter int CODE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              act_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              fire_o
);
  localparam int DIV_LOG = (1 << CODE_W) - 1;
  localparam int CW      = (DIV_LOG < 1) ? 1 : DIV_LOG;

  logic [CW-1:0] cnt_q, mask;
  logic [7:0]    mask_full;

  assign mask_full = div_mask(3'(code_i));
  assign mask      = mask_full[CW-1:0];
  assign fire_o    = act_i && ((cnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else if (act_i) cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/cap_latch.sv
module cap_latch #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             flag_o,
  output logic             ovr_o
);
  logic [CNT_W-1:0] cap_q;
  logic             flag_q, ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (fire_i) cap_q <= cnt_i;
      flag_q <= fire_i | (flag_q & ~clr_i);
      // clear wins over a stale flag when both arrive together
      ovr_q  <= ~clr_i & (ovr_q | (fire_i & flag_q));
    end
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;
  assign ovr_o  = ovr_q;
endmodule

// File: rtl/capture_front.sv
module capture_front
  import cap_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int CODE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sel_wr_i,
  input  logic [1:0]        sel_i,
  input  logic [CODE_W-1:0] psc_i,
  input  logic              pol_i,
  input  logic              own_i,
  input  logic              sib_i,
  input  logic              trig_i,
  input  logic              trig_ok_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              clr_i,
  output logic [1:0]        sel_o,
  output logic [CNT_W-1:0]  cap_o,
  output logic              flag_o,
  output logic              ovr_o
);
  src_sel_e sel;
  logic     act, fire;

  cap_sel_reg u_sel (
    .clk_i, .rst_ni, .en_i,
    .wr_i  (sel_wr_i),
    .sel_i (sel_i),
    .sel_o (sel)
  );

  cap_edge_src u_edge (
    .clk_i, .rst_ni, .en_i,
    .sel_i     (sel),
    .pol_i     (pol_i),
    .own_i     (own_i),
    .sib_i     (sib_i),
    .trig_i    (trig_i),
    .trig_ok_i (trig_ok_i),
    .act_o     (act)
  );

  cap_presc #(.CODE_W(CODE_W)) u_presc (
    .clk_i, .rst_ni, .en_i,
    .act_i  (act),
    .code_i (psc_i),
    .fire_o (fire)
  );

  cap_latch #(.CNT_W(CNT_W)) u_latch (
    .clk_i, .rst_ni,
    .fire_i (fire),
    .clr_i  (clr_i),
    .cnt_i  (cnt_i),
    .cap_o  (cap_o),
    .flag_o (flag_o),
    .ovr_o  (ovr_o)
  );

  assign sel_o = sel;
endmodule

// File: rtl/capture_front_chk.sv
module capture_front_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             sel_wr_i,
  input logic             trig_ok_i,
  input logic             clr_i,
  input logic [1:0]       sel_o,
  input logic [CNT_W-1:0] cap_o,
  input logic             flag_o,
  input logic             ovr_o
);
  // R5
  sel_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sel_wr_i) |=> $stable(sel_o));

  // R2
  off_no_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o == 2'b00) |=> ($stable(cap_o) && !$rose(flag_o)));

  // R4
  trig_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o == 2'b11 && !trig_ok_i) |=> ($stable(cap_o) && !$rose(flag_o)));

  // R7
  dis_no_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(cap_o) && !$rose(flag_o)));

  // R9
  clr_ovr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !ovr_o);

  // R10
  ovr_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |-> flag_o);
endmodule

bind capture_front capture_front_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .sel_wr_i  (sel_wr_i),
  .trig_ok_i (trig_ok_i),
  .clr_i     (clr_i),
  .sel_o     (sel_o),
  .cap_o     (cap_o),
  .flag_o    (flag_o),
  .ovr_o     (ovr_o)
);

// File: tb/capture_front_bench.sv
`timescale 1ns/1ps
module capture_front_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 0, sel_wr = 0, pol = 0, own = 0, sib = 0, trig = 0, trig_ok = 0, clr = 0;
  logic [1:0]  sel = 0, psc = 0;
  logic [15:0] cnt = 0;
  logic [1:0]  sel_o;
  logic [15:0] cap_o;
  logic        flag_o, ovr_o;

  int compared = 0, mismatched = 0, cycles = 0;

  always #4 clk = ~clk;

  capture_front u_capture_front (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sel_wr_i(sel_wr), .sel_i(sel),
    .psc_i(psc), .pol_i(pol), .own_i(own), .sib_i(sib), .trig_i(trig),
    .trig_ok_i(trig_ok), .cnt_i(cnt), .clr_i(clr),
    .sel_o(sel_o), .cap_o(cap_o), .flag_o(flag_o), .ovr_o(ovr_o)
  );

  // reference model, written from the requirements
  logic [1:0]  m_sel;
  logic        m_prev, m_flag, m_ovr;
  logic [15:0] m_cap;
  int          m_edges;

  function automatic logic src_level(logic [1:0] s, logic a, logic b, logic t);
    case (s)
      2'b01:   return a;
      2'b10:   return b;
      2'b11:   return t;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic is_active(logic [1:0] s, logic ok, logic p, logic prv, logic now);
    if (s == 2'b00) return 1'b0;
    if (s == 2'b11 && !ok) return 1'b0;
    return p ? (prv && !now) : (!prv && now);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel <= 0; m_prev <= 0; m_flag <= 0; m_ovr <= 0; m_cap <= 0; m_edges <= 0;
    end else begin
      logic lv, hit;
      lv  = src_level(m_sel, own, sib, trig);
      hit = 1'b0;
      if (!en) m_edges <= 0;
      else if (is_active(m_sel, trig_ok, pol, m_prev, lv)) begin
        if (m_edges + 1 == (1 << psc)) begin hit = 1'b1; m_edges <= 0; end
        else m_edges <= m_edges + 1;
      end
      m_prev <= lv;
      if (sel_wr && !en) m_sel <= sel;
      if (hit) m_cap <= cnt;
      if (clr) begin m_flag <= hit; m_ovr <= 1'b0; end
      else begin m_flag <= m_flag | hit; m_ovr <= m_ovr | (hit & m_flag); end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    if (rst_n) begin
      chk("R5 model sel_o", 32'(sel_o), 32'(m_sel));
      chk("R9 model cap_o", 32'(cap_o), 32'(m_cap));
      chk("R6 model flag_o", 32'(flag_o), 32'(m_flag));
      chk("R10 model ovr_o", 32'(ovr_o), 32'(m_ovr));
    end
  endtask

  task automatic cfg(logic [1:0] s, logic [1:0] p, logic pl);
    en = 0; own = 0; sib = 0; trig = 0; clr = 1;
    sel_wr = 1; sel = s; psc = p; pol = pl;
    step();
    sel_wr = 0; clr = 0;
    step(); step();
    en = 1;
  endtask

  // which: 0 own, 1 sib, 2 trig
  task automatic drive(int which, logic v, logic [15:0] c);
    cnt = c;
    case (which)
      0: own = v;
      1: sib = v;
      default: trig = v;
    endcase
    step();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        mismatched++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 reset sel_o", 32'(sel_o), 0);
    chk("R1 reset cap_o", 32'(cap_o), 0);
    chk("R1 reset flags", {30'b0, flag_o, ovr_o}, 0);

    // R2: output use, edges ignored
    cfg(2'b00, 2'b00, 1'b0);
    drive(0, 1, 16'h0aaa); drive(0, 0, 16'h0aab); drive(1, 1, 16'h0aac);
    chk("R2 no capture flag", 32'(flag_o), 0);
    chk("R2 no capture cap", 32'(cap_o), 0);

    // R3: own then sibling
    cfg(2'b01, 2'b00, 1'b0);
    drive(0, 1, 16'h1111);
    chk("R3 own flag", 32'(flag_o), 1);
    chk("R3 own cap", 32'(cap_o), 32'h1111);
    drive(0, 0, 16'h1112);
    clr = 1; step(); clr = 0;
    drive(1, 1, 16'h2222);
    chk("R3 unselected sib flag", 32'(flag_o), 0);
    chk("R3 unselected sib cap", 32'(cap_o), 32'h1111);
    cfg(2'b10, 2'b00, 1'b0);
    drive(1, 1, 16'h3333);
    chk("R3 sib cap", 32'(cap_o), 32'h3333);

    // R5: locked write, then unlocked write
    sel_wr = 1; sel = 2'b01; step(); sel_wr = 0;
    chk("R5 locked sel_o", 32'(sel_o), 32'h2);
    en = 0; step();
    sel_wr = 1; sel = 2'b11; step(); sel_wr = 0;
    chk("R5 unlocked sel_o", 32'(sel_o), 32'h3);

    // R4: trigger gated by trig_ok
    cfg(2'b11, 2'b00, 1'b0);
    trig_ok = 0;
    drive(2, 1, 16'h4444); drive(2, 0, 16'h4445);
    chk("R4 gated trig flag", 32'(flag_o), 0);
    trig_ok = 1;
    drive(2, 1, 16'h5555);
    chk("R4 valid trig cap", 32'(cap_o), 32'h5555);

    // R8: falling polarity
    cfg(2'b01, 2'b00, 1'b1);
    drive(0, 1, 16'h6666);
    chk("R8 rise ignored when falling", 32'(flag_o), 0);
    drive(0, 0, 16'h7777);
    chk("R8 falling cap", 32'(cap_o), 32'h7777);

    // R6: divide by 4
    cfg(2'b01, 2'b10, 1'b0);
    for (int k = 0; k < 3; k++) begin drive(0, 1, 16'h8000 + 16'(k)); drive(0, 0, 16'h9000); end
    chk("R6 div4 after 3 edges", 32'(flag_o), 0);
    drive(0, 1, 16'h8003);
    chk("R6 div4 4th edge cap", 32'(cap_o), 32'h8003);
    chk("R6 div4 4th edge flag", 32'(flag_o), 1);

    // R7: divider reset on disable, no capture when disabled
    cfg(2'b01, 2'b01, 1'b0);
    drive(0, 1, 16'ha001); drive(0, 0, 16'ha002);
    en = 0; drive(0, 1, 16'ha003); drive(0, 0, 16'ha004);
    chk("R7 disabled no capture", 32'(flag_o), 0);
    en = 1;
    drive(0, 1, 16'ha005); drive(0, 0, 16'ha006);
    chk("R7 divider was cleared", 32'(flag_o), 0);
    drive(0, 1, 16'ha007);
    chk("R7 second edge captures", 32'(cap_o), 32'ha007);

    // R10 overcapture, R9 clear and clear-with-capture
    cfg(2'b01, 2'b00, 1'b0);
    drive(0, 1, 16'hb001); drive(0, 0, 16'hb002);
    drive(0, 1, 16'hb003);
    chk("R10 overcapture", 32'(ovr_o), 1);
    drive(0, 0, 16'hb004);
    clr = 1; step(); clr = 0;
    chk("R9 clear flags", {30'b0, flag_o, ovr_o}, 0);
    drive(0, 1, 16'hb005); drive(0, 0, 16'hb006);
    clr = 1; drive(0, 1, 16'hb007); clr = 0;
    chk("R9 clear+capture flag", 32'(flag_o), 1);
    chk("R9 clear+capture ovr", 32'(ovr_o), 0);

    // constrained random
    for (int ph = 0; ph < 200; ph++) begin
      en = 0; sel_wr = 1; sel = 2'($urandom); psc = 2'($urandom); pol = 1'($urandom);
      step();
      sel_wr = 0;
      repeat (2) step();
      en = 1;
      for (int i = 0, n = 10 + $urandom % 40; i < n; i++) begin
        own = 1'($urandom); sib = 1'($urandom); trig = 1'($urandom);
        trig_ok = ($urandom % 4) != 0;
        cnt = 16'($urandom);
        clr = ($urandom % 8) == 0;
        sel_wr = ($urandom % 6) == 0;
        sel = 2'($urandom);
        step();
      end
      clr = 0; sel_wr = 0;
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule